// File: doc/BRIEF.md
# Converter Calibration Sequencer

This block runs the start-up calibration of a two-channel measurement front end. It drives two active-low analog switch enables. One switch passes the sensor signal into the converter chain. The other switch ties that chain to ground. It also drives a calibration strobe that is shared by every converter channel. The strobe is high from reset. Its falling edge starts an offset-then-gain calibration in each converter. While the input is grounded, only circuit offsets reach the converters, so they take their zero point there. They then take their full-scale point from their reference.

The processor sets two select bits and sends a one-cycle calibration request. The `sel_gnd` bit routes the front end to ground. When `sel_gnd` is clear, the sensor is connected. The `sel_iso` bit, together with `sel_gnd`, leaves both switches open. A request is accepted only when the front end is grounded and the block is idle. An accepted request drops the strobe and raises `busy`. The block then gathers a done pulse from every channel, in any order. When the last one arrives, it pulses `cal_done`, releases `busy` and raises the strobe again, so that a later calibration can be requested.

Top module: `cal_seq_top`

## Requirements
- R1: While `rst` is high, the outputs read `sig_en_n`=1, `gnd_en_n`=1, `cal_strobe`=1, `busy`=0, `cal_done`=0 and `cal_err`=0. The same values hold in the first cycle after reset is released.
- R2: With `sel_gnd`=1 and `sel_iso`=0, the switches settle to the grounded state: `sig_en_n`=1 and `gnd_en_n`=0.
- R3: With `sel_gnd`=0, the switches settle to the sensor-connected state: `sig_en_n`=0 and `gnd_en_n`=1.
- R4: With `sel_gnd`=1 and `sel_iso`=1, the switches settle to the isolated state, with both enables at 1.
- R5: Both enables are never 0 together. A move between the grounded and the connected state spends exactly one cycle with both enables at 1. The new select value is registered on the first clock edge, and the break and the make follow on the next two edges.
- R6: A request made while the switches are grounded and the block is idle drops `cal_strobe` to 0 and raises `busy` at the next clock edge.
- R7: A request made while the switches are not grounded, or while `busy` is 1, is ignored. It gives a one-cycle `cal_err` pulse, and `cal_strobe` and `busy` keep their values.
- R8: `busy` stays at 1 until a done pulse has been seen on every bit of `ch_done`, whether those pulses come in the same cycle or in different cycles. At the edge that sees the last one, `busy` falls, `cal_strobe` rises and `cal_done` pulses for one cycle.
- R9: Select changes made while `busy` is 1 have no effect on the switch enables.
- R10: A `ch_done` pulse that arrives while the block is idle is ignored. It gives no `cal_done`, and the next calibration still waits for every channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_gnd | input | 1 | Processor select: route the front end to ground |
| sel_iso | input | 1 | Processor select: with sel_gnd, leave both switches open |
| cal_req | input | 1 | One-cycle calibration request |
| ch_done | input | N_CH | Per-channel calibration-complete pulses |
| sig_en_n | output | 1 | Active-low enable of the sensor-signal switch |
| gnd_en_n | output | 1 | Active-low enable of the input-ground switch |
| cal_strobe | output | 1 | Calibration strobe to all converters; a falling edge starts calibration |
| busy | output | 1 | Calibration in progress |
| cal_done | output | 1 | One-cycle pulse when every channel has finished |
| cal_err | output | 1 | One-cycle pulse for a rejected request |

## Verification
The hardest case to reach is a select change that arrives in the middle of a calibration while one channel has already reported and the other has not. The switch lock and the per-channel done memory are then both under test at once. The stimulus reaches this case in four steps:
1. Ground the input and start a calibration.
2. Clear `sel_gnd` and send a second request while `busy` is high.
3. Finish one channel, then restore the select.
4. Finish the other channel.

The enables must stay grounded throughout. A done pulse sent while idle, just before a later calibration starts, shows that no stale completion carries over.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

    typedef enum logic [1:0] {
        SW_OPEN = 2'd0,
        SW_SIG  = 2'd1,
        SW_GND  = 2'd2
    } sw_state_t;

    function automatic sw_state_t sel_to_target(input logic gnd, input logic iso);
        if (!gnd)
            return SW_SIG;
        else if (iso)
            return SW_OPEN;
        else
            return SW_GND;
    endfunction

endpackage

// File: rtl/cal_switch_ctl.sv
module cal_switch_ctl
    import cal_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sel_gnd,
    input  logic      sel_iso,
    input  logic      lock,
    output sw_state_t state,
    output sw_state_t target,
    output logic      sig_en_n,
    output logic      gnd_en_n
);

    sw_state_t tgt_q;
    sw_state_t st_q;

    // target follows the selects unless a calibration holds it
    always_ff @(posedge clk) begin
        if (rst)
            tgt_q <= SW_OPEN;
        else if (!lock)
            tgt_q <= sel_to_target(sel_gnd, sel_iso);
    end

    // break before make: a closed switch always passes through OPEN
    always_ff @(posedge clk) begin
        if (rst)
            st_q <= SW_OPEN;
        else if (st_q != tgt_q) begin
            if (st_q == SW_OPEN)
                st_q <= tgt_q;
            else
                st_q <= SW_OPEN;
        end
    end

    always_comb begin
        state    = st_q;
        target   = tgt_q;
        sig_en_n = (st_q != SW_SIG);
        gnd_en_n = (st_q != SW_GND);
    end

    assert_bbm_sig_R5: assert property (@(posedge clk) disable iff (rst)
        $past(st_q) == SW_SIG |-> st_q != SW_GND);
    assert_bbm_gnd_R5: assert property (@(posedge clk) disable iff (rst)
        $past(st_q) == SW_GND |-> st_q != SW_SIG);
    assert_lock_R9: assert property (@(posedge clk) disable iff (rst)
        lock && $past(lock) |-> $stable(tgt_q));

endmodule

// File: rtl/cal_chan_track.sv
module cal_chan_track (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic arm,
    input  logic done_in,
    output logic have
);

    logic seen_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            seen_q <= 1'b0;
        else if (arm && done_in)
            seen_q <= 1'b1;
    end

    always_comb have = seen_q | (arm & done_in);

    assert_keep_R8: assert property (@(posedge clk) disable iff (rst)
        arm && seen_q && !clr |=> seen_q);
    assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !arm && !seen_q |=> !seen_q);

endmodule

// File: rtl/cal_seq_top.sv
module cal_seq_top
    import cal_seq_pkg::*;
#(
    parameter int N_CH = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sel_gnd,
    input  logic            sel_iso,
    input  logic            cal_req,
    input  logic [N_CH-1:0] ch_done,
    output logic            sig_en_n,
    output logic            gnd_en_n,
    output logic            cal_strobe,
    output logic            busy,
    output logic            cal_done,
    output logic            cal_err
);

    sw_state_t       sw_st;
    sw_state_t       sw_tgt;
    logic            busy_q, strobe_q, done_q, err_q;
    logic [N_CH-1:0] have;
    logic            accept, all_done;

    cal_switch_ctl u_sw (
        .clk      (clk),
        .rst      (rst),
        .sel_gnd  (sel_gnd),
        .sel_iso  (sel_iso),
        .lock     (busy_q),
        .state    (sw_st),
        .target   (sw_tgt),
        .sig_en_n (sig_en_n),
        .gnd_en_n (gnd_en_n)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        cal_chan_track u_trk (
            .clk     (clk),
            .rst     (rst),
            .clr     (accept),
            .arm     (busy_q),
            .done_in (ch_done[c]),
            .have    (have[c])
        );
    end

    always_comb begin
        accept   = cal_req && !busy_q && (sw_st == SW_GND) && (sw_tgt == SW_GND);
        all_done = busy_q && (&have);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b1;
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (accept) begin
                strobe_q <= 1'b0;
                busy_q   <= 1'b1;
            end else if (cal_req) begin
                err_q <= 1'b1;
            end
            if (all_done) begin
                strobe_q <= 1'b1;
                busy_q   <= 1'b0;
                done_q   <= 1'b1;
            end
        end
    end

    always_comb begin
        cal_strobe = strobe_q;
        busy       = busy_q;
        cal_done   = done_q;
        cal_err    = err_q;
    end

    assert_fall_grounded_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(cal_strobe) |-> !gnd_en_n && sig_en_n);
    assert_err_no_start_R7: assert property (@(posedge clk) disable iff (rst)
        cal_err |-> !$rose(busy));
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        cal_done |=> !cal_done);
    assert_busy_end_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> cal_done && cal_strobe);
    assert_hold_switch_R9: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) |-> $stable(gnd_en_n) && $stable(sig_en_n));

endmodule

// File: tb/test_cal_seq_top.sv
module test_cal_seq_top;

    localparam int CLK_PERIOD = 10;
    localparam int N_CH       = 2;
    localparam int WDOG       = 5000;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            sel_gnd = 1'b0;
    logic            sel_iso = 1'b0;
    logic            cal_req = 1'b0;
    logic [N_CH-1:0] ch_done = '0;
    logic            sig_en_n, gnd_en_n, cal_strobe, busy, cal_done, cal_err;

    cal_seq_top #(.N_CH(N_CH)) i_cal_seq_top (
        .clk        (clk),
        .rst        (rst),
        .sel_gnd    (sel_gnd),
        .sel_iso    (sel_iso),
        .cal_req    (cal_req),
        .ch_done    (ch_done),
        .sig_en_n   (sig_en_n),
        .gnd_en_n   (gnd_en_n),
        .cal_strobe (cal_strobe),
        .busy       (busy),
        .cal_done   (cal_done),
        .cal_err    (cal_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int         due;
        logic [5:0] val;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: {sig_en_n, gnd_en_n, cal_strobe, busy, cal_done, cal_err}
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due == cyc) begin
            exp_t e;
            logic [5:0] act;
            e   = q.pop_front();
            act = {sig_en_n, gnd_en_n, cal_strobe, busy, cal_done, cal_err};
            checks++;
            if (act !== e.val) begin
                errors++;
                $display("FAIL %s: actual %b expected %b (cycle %0d)", e.tag, act, e.val, cyc);
            end
        end
    end

    // driver: apply inputs for one cycle and queue the outputs expected after the edge
    task automatic step(input logic g, input logic iso, input logic req,
                        input logic [N_CH-1:0] dn, input logic [5:0] exp_v,
                        input string tag);
        exp_t e;
        sel_gnd = g;
        sel_iso = iso;
        cal_req = req;
        ch_done = dn;
        e.due = cyc + 1;
        e.val = exp_v;
        e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        #1;
    endtask

    initial begin
        @(negedge clk);
        #1;
        // R1: reset values while reset is held
        step(0, 0, 0, 2'b00, 6'b111000, "R1 reset");
        step(0, 0, 0, 2'b00, 6'b111000, "R1 reset");
        rst = 1'b0;
        step(0, 0, 0, 2'b00, 6'b111000, "R1 after release");
        step(0, 0, 0, 2'b00, 6'b011000, "R3 connected");
        // R7: request with sensor connected
        step(0, 0, 1, 2'b00, 6'b011001, "R7 reject connected");
        step(0, 0, 0, 2'b00, 6'b011000, "R7 err one cycle");
        // R2/R5: connected -> grounded through open
        step(1, 0, 0, 2'b00, 6'b011000, "R5 target latch");
        step(1, 0, 0, 2'b00, 6'b111000, "R5 break");
        step(1, 0, 0, 2'b00, 6'b101000, "R2 grounded");
        // R6: accepted request
        step(1, 0, 1, 2'b00, 6'b100100, "R6 start");
        // R9: select change while busy
        step(0, 0, 0, 2'b00, 6'b100100, "R9 locked");
        step(0, 0, 0, 2'b00, 6'b100100, "R9 locked");
        // R7: request while busy
        step(0, 0, 1, 2'b00, 6'b100101, "R7 reject busy");
        step(0, 0, 0, 2'b01, 6'b100100, "R8 one channel");
        step(1, 0, 0, 2'b00, 6'b100100, "R8 still busy");
        step(1, 0, 0, 2'b10, 6'b101010, "R8 last channel");
        step(1, 0, 0, 2'b00, 6'b101000, "R8 done one cycle");
        step(1, 0, 0, 2'b00, 6'b101000, "R9 stays grounded");
        // R8: both channels in one cycle
        step(1, 0, 1, 2'b00, 6'b100100, "R6 restart");
        step(1, 0, 0, 2'b11, 6'b101010, "R8 both together");
        // R10: done while idle is ignored
        step(1, 0, 0, 2'b01, 6'b101000, "R10 idle done");
        step(1, 0, 1, 2'b00, 6'b100100, "R6 third start");
        step(1, 0, 0, 2'b10, 6'b100100, "R10 still waiting");
        step(1, 0, 0, 2'b01, 6'b101010, "R10 completes");
        // R4: isolate
        step(1, 1, 0, 2'b00, 6'b101000, "R4 target latch");
        step(1, 1, 0, 2'b00, 6'b111000, "R4 isolated");
        step(1, 1, 1, 2'b00, 6'b111001, "R7 reject isolated");
        step(1, 1, 0, 2'b00, 6'b111000, "R4 held");
        // R3/R5: back to connected, then grounded -> connected break
        step(0, 0, 0, 2'b00, 6'b111000, "R3 target latch");
        step(0, 0, 0, 2'b00, 6'b011000, "R3 connected again");
        step(1, 0, 0, 2'b00, 6'b011000, "R5 latch");
        step(1, 0, 0, 2'b00, 6'b111000, "R5 break");
        step(1, 0, 0, 2'b00, 6'b101000, "R2 grounded again");
        step(0, 0, 0, 2'b00, 6'b101000, "R5 latch back");
        step(0, 0, 0, 2'b00, 6'b111000, "R5 break back");
        step(0, 0, 0, 2'b00, 6'b011000, "R3 connected final");
        step(0, 0, 0, 2'b00, 6'b011000, "R3 stable");
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule